// File: doc/BRIEF.md
# Power Metering Computation Cycle Engine

The engine takes one signed voltage sample and one signed current sample per conversion strobe. Both are 24-bit two's complement fractions, with 0x800000 standing for -1 and 0x7FFFFF for just under +1. For every pair it forms an instantaneous power sample at once. It also adds the squared voltage, the squared current and the power into wide accumulators. After a programmable number N of conversions (one computation cycle) it takes a snapshot of the three sums and clears the accumulators, so that the next cycle starts collecting without a gap.

A single sequencer works through the snapshot. One shared restoring divider forms the two mean squares and the mean power. A bit-serial integer square root then turns each mean square into an unsigned RMS fraction. All three results are published together, and the data-ready status bit is set on that same edge.

Two status bits are kept: conversion-ready and data-ready. Once set, a bit stays set until software clears it. A mask of the same layout gates which set bits drive the interrupt output. Writing a new N restarts the cycle. A flag reports when N is too small for the RMS values to mean much.

Top module: `pmeter_cycle_engine`

## Requirements
- R1: On the edge that accepts a strobe, `p_inst` takes floor(v*i / 2^23) as a 24-bit signed code. The single overflow case, v = i = 0x800000, gives 0x7FFFFF.
- R2: Status bit 0 (conversion-ready) is 1 after every edge that accepts a strobe.
- R3: After the N-th conversion of a cycle, `v_rms` becomes min(isqrt(4*floor(S/N)), 0xFFFFFF), where S is the sum of v^2 over the cycle. `i_rms` is formed the same way from i^2.
- R4: `energy` becomes the cycle's sum of power samples divided by N and truncated toward zero, as a 24-bit signed code.
- R5: Status bit 1 (data-ready) sets on the edge where the three results are published. The results change on no other edge. Publication takes place within 320 clocks of the cycle's last strobe.
- R6: A set status bit stays 1 until a clear write carries a 1 in that bit position. If a set event and a clear of the same bit fall on one edge, the bit stays 1.
- R7: `irq` is 1 exactly when some status bit is 1 and the mask bit in the same position (bit 0 conversion, bit 1 data) is 1.
- R8: A write of N clears the accumulators and the conversion count. A strobe on the same edge is counted as the first conversion of the new cycle. A written value of 0 acts as 1.
- R9: With N = 1 every conversion closes a cycle. `energy` then equals that conversion's power sample, and each RMS value equals twice the sample's magnitude in unsigned code.
- R10: `n_low` is 1 while the current N is 10 or less. Results are still computed in that case.
- R11: A cycle whose samples are all -1 yields 0xFFFFFF, never a wrapped value.
- R12: After reset the status bits, the mask, the results, `p_inst` and `irq` are 0, and N takes the parameter `N_RST` (default 4000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Conversion strobe, one sample pair |
| v_smp | input | 24 | Voltage sample, signed fraction |
| i_smp | input | 24 | Current sample, signed fraction |
| ncyc_wr | input | 1 | Write strobe for the cycle length |
| ncyc_val | input | 24 | New cycle length N |
| stat_clr_wr | input | 1 | Status clear strobe |
| stat_clr_bits | input | 2 | Status bits to clear (1 = clear) |
| mask_wr | input | 1 | Mask write strobe |
| mask_bits | input | 2 | New mask value |
| p_inst | output | 24 | Instantaneous power sample |
| v_rms | output | 24 | RMS voltage, unsigned fraction |
| i_rms | output | 24 | RMS current, unsigned fraction |
| energy | output | 24 | Mean power over the cycle, signed fraction |
| status | output | 2 | Bit 0 conversion-ready, bit 1 data-ready |
| mask | output | 2 | Interrupt enables, same layout as status |
| irq | output | 1 | Interrupt request |
| n_low | output | 1 | N is 10 or less |

## Verification
Two pairs of functions can meet on one edge, and the bench provokes both.

In the first pair, a status clear for the conversion bit is driven in the same cycle as a new strobe. The bench then expects the bit to read 1, whereas a clear driven alone must read 0.

In the second pair, a write of N lands together with a strobe. The bench's model restarts the cycle at that edge and counts the sample as its first. The published RMS and energy values after the shortened cycle must match the model exactly.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int ST_CONV   = 0;
    localparam int ST_DATA   = 1;
    localparam int NSTAT     = 2;
    localparam int RMS_MIN_N = 10;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_DLOAD,
        SEQ_DWAIT,
        SEQ_RLOAD,
        SEQ_RWAIT,
        SEQ_PUB
    } seq_e;

endpackage

// File: rtl/pm_serial_div.sv
module pm_serial_div #(
    parameter int DW = 71,
    parameter int VW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic [DW-1:0] quotient,
    output logic          done
);
    localparam int CNTW = $clog2(DW + 1);

    typedef struct packed {
        logic            run;
        logic            fin;
        logic [CNTW-1:0] cnt;
        logic [VW-1:0]   dvs;
        logic [VW-1:0]   rem;
        logic [DW-1:0]   dvd;
    } div_t;

    div_t        q, d;
    logic [VW:0] cand;
    logic        qbit;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        cand  = {q.rem, q.dvd[DW-1]};
        qbit  = 1'b0;
        if (start) begin
            d.run = 1'b1;
            d.cnt = '0;
            d.dvs = divisor;
            d.rem = '0;
            d.dvd = dividend;
        end else if (q.run) begin
            if (cand >= {1'b0, q.dvs}) begin
                qbit  = 1'b1;
                d.rem = VW'(cand - {1'b0, q.dvs});
            end else begin
                d.rem = cand[VW-1:0];
            end
            d.dvd = {q.dvd[DW-2:0], qbit};
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNTW'(DW - 1)) begin
                d.run = 1'b0;
                d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign quotient = q.dvd;
    assign done     = q.fin;

endmodule

// File: rtl/pm_isqrt.sv
module pm_isqrt #(
    parameter int RW = 50
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [RW-1:0]   radicand,
    output logic [RW/2-1:0] root,
    output logic            done
);
    localparam int HW   = RW / 2;
    localparam int RMW  = HW + 2;
    localparam int CNTW = $clog2(HW + 1);

    typedef struct packed {
        logic            run;
        logic            fin;
        logic [CNTW-1:0] cnt;
        logic [RW-1:0]   rad;
        logic [RMW-1:0]  rem;
        logic [HW-1:0]   res;
    } sq_t;

    sq_t            q, d;
    logic [RMW-1:0] nrem;
    logic [RMW-1:0] trial;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        nrem  = {q.rem[RMW-3:0], q.rad[RW-1:RW-2]};
        trial = {q.res, 2'b01};
        if (start) begin
            d.run = 1'b1;
            d.cnt = '0;
            d.rad = radicand;
            d.rem = '0;
            d.res = '0;
        end else if (q.run) begin
            d.rad = {q.rad[RW-3:0], 2'b00};
            if (nrem >= trial) begin
                d.rem = nrem - trial;
                d.res = {q.res[HW-2:0], 1'b1};
            end else begin
                d.rem = nrem;
                d.res = {q.res[HW-2:0], 1'b0};
            end
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNTW'(HW - 1)) begin
                d.run = 1'b0;
                d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign root = q.res;
    assign done = q.fin;

endmodule

// File: rtl/pm_status.sv
module pm_status #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_evt,
    input  logic          clr_wr,
    input  logic [NB-1:0] clr_bits,
    input  logic          msk_wr,
    input  logic [NB-1:0] msk_bits,
    output logic [NB-1:0] stat,
    output logic [NB-1:0] msk,
    output logic          irq
);
    typedef struct packed {
        logic [NB-1:0] st;
        logic [NB-1:0] mk;
    } stat_t;

    stat_t q, d;

    always_comb begin
        d = q;
        if (clr_wr) d.st = q.st & ~clr_bits;
        d.st = d.st | set_evt;
        if (msk_wr) d.mk = msk_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stat = q.st;
    assign msk  = q.mk;
    assign irq  = |(q.st & q.mk);

endmodule

// File: rtl/pmeter_cycle_engine.sv
module pmeter_cycle_engine
    import pm_pkg::*;
#(
    parameter int          SW    = 24,
    parameter int          CW    = 24,
    parameter logic [23:0] N_RST = 24'd4000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [SW-1:0] v_smp,
    input  logic [SW-1:0] i_smp,
    input  logic          ncyc_wr,
    input  logic [CW-1:0] ncyc_val,
    input  logic          stat_clr_wr,
    input  logic [1:0]    stat_clr_bits,
    input  logic          mask_wr,
    input  logic [1:0]    mask_bits,
    output logic [SW-1:0] p_inst,
    output logic [SW-1:0] v_rms,
    output logic [SW-1:0] i_rms,
    output logic [SW-1:0] energy,
    output logic [1:0]    status,
    output logic [1:0]    mask,
    output logic          irq,
    output logic          n_low
);
    localparam int SQ_W   = 2 * SW;
    localparam int ACC_W  = SQ_W + CW - 1;
    localparam int PACC_W = SW + CW + 1;
    localparam int RAD_W  = SQ_W + 2;
    localparam int RT_W   = RAD_W / 2;
    localparam logic [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};
    localparam logic [SW-1:0] SMAX = {1'b0, {(SW-1){1'b1}}};

    typedef struct packed {
        logic [CW-1:0]     nq;
        logic [CW-1:0]     cnt;
        logic [ACC_W-1:0]  acc_v;
        logic [ACC_W-1:0]  acc_i;
        logic [PACC_W-1:0] acc_p;
        logic [ACC_W-1:0]  snap_v;
        logic [ACC_W-1:0]  snap_i;
        logic [PACC_W-1:0] snap_p;
        logic [CW-1:0]     snap_n;
        logic [SW-1:0]     p_inst;
        seq_e              seq;
        logic [1:0]        op;
        logic [SQ_W-1:0]   ms_v;
        logic [SQ_W-1:0]   ms_i;
        logic [SW-1:0]     v_stage;
        logic [SW-1:0]     i_stage;
        logic [SW-1:0]     e_stage;
        logic [SW-1:0]     v_rms;
        logic [SW-1:0]     i_rms;
        logic [SW-1:0]     energy;
    } eng_t;

    eng_t q, d;

    logic signed [SW-1:0]   v_s, i_s, p_s;
    logic signed [SQ_W-1:0] prod, prod_sh, vsq, isq;
    logic [SW-1:0]          p_new;
    logic [CW-1:0]          n_eff, cnt_b;
    logic [ACC_W-1:0]       acc_vb, acc_ib, sum_v, sum_i;
    logic [PACC_W-1:0]      acc_pb, sum_p, mag_p;
    logic                   div_start, div_done, sq_start, sq_done, p_neg;
    logic [ACC_W-1:0]       div_dvd, div_quo;
    logic [RAD_W-1:0]       sq_rad;
    logic [RT_W-1:0]        sq_root;
    logic [SW-1:0]          e_mag, rt_val;
    logic [1:0]             set_evt;

    always_comb begin
        v_s     = $signed(v_smp);
        i_s     = $signed(i_smp);
        prod    = v_s * i_s;
        vsq     = v_s * v_s;
        isq     = i_s * i_s;
        prod_sh = prod >>> (SW - 1);
        p_new   = (v_s == $signed(SMIN) && i_s == $signed(SMIN)) ? SMAX : prod_sh[SW-1:0];
        p_s     = $signed(p_new);
    end

    always_comb begin
        p_neg  = q.snap_p[PACC_W-1];
        mag_p  = p_neg ? (~q.snap_p + 1'b1) : q.snap_p;
        e_mag  = div_quo[SW-1:0];
        rt_val = sq_root[SW] ? {SW{1'b1}} : sq_root[SW-1:0];
        case (q.op)
            2'd0:    div_dvd = q.snap_v;
            2'd1:    div_dvd = q.snap_i;
            default: div_dvd = ACC_W'(mag_p);
        endcase
        sq_rad = (q.op == 2'd0) ? {q.ms_v, 2'b00} : {q.ms_i, 2'b00};
    end

    always_comb begin
        d         = q;
        div_start = 1'b0;
        sq_start  = 1'b0;

        case (q.seq)
            SEQ_DLOAD: begin
                div_start = 1'b1;
                d.seq     = SEQ_DWAIT;
            end
            SEQ_DWAIT: begin
                if (div_done) begin
                    case (q.op)
                        2'd0:    d.ms_v    = div_quo[SQ_W-1:0];
                        2'd1:    d.ms_i    = div_quo[SQ_W-1:0];
                        default: d.e_stage = p_neg ? (~e_mag + 1'b1) : e_mag;
                    endcase
                    if (q.op == 2'd2) begin
                        d.op  = 2'd0;
                        d.seq = SEQ_RLOAD;
                    end else begin
                        d.op  = q.op + 1'b1;
                        d.seq = SEQ_DLOAD;
                    end
                end
            end
            SEQ_RLOAD: begin
                sq_start = 1'b1;
                d.seq    = SEQ_RWAIT;
            end
            SEQ_RWAIT: begin
                if (sq_done) begin
                    if (q.op == 2'd0) begin
                        d.v_stage = rt_val;
                        d.op      = 2'd1;
                        d.seq     = SEQ_RLOAD;
                    end else begin
                        d.i_stage = rt_val;
                        d.op      = 2'd0;
                        d.seq     = SEQ_PUB;
                    end
                end
            end
            SEQ_PUB: begin
                d.v_rms  = q.v_stage;
                d.i_rms  = q.i_stage;
                d.energy = q.e_stage;
                d.seq    = SEQ_IDLE;
            end
            default: d.seq = SEQ_IDLE;
        endcase

        if (ncyc_wr) begin
            n_eff  = (ncyc_val == '0) ? CW'(1) : ncyc_val;
            cnt_b  = '0;
            acc_vb = '0;
            acc_ib = '0;
            acc_pb = '0;
        end else begin
            n_eff  = q.nq;
            cnt_b  = q.cnt;
            acc_vb = q.acc_v;
            acc_ib = q.acc_i;
            acc_pb = q.acc_p;
        end
        d.nq = n_eff;

        sum_v = acc_vb + ACC_W'($unsigned(vsq));
        sum_i = acc_ib + ACC_W'($unsigned(isq));
        sum_p = $unsigned($signed(acc_pb) + PACC_W'(p_s));

        if (smp_valid) begin
            d.p_inst = p_new;
            if (CW'(cnt_b + 1'b1) == n_eff) begin
                d.snap_v = sum_v;
                d.snap_i = sum_i;
                d.snap_p = sum_p;
                d.snap_n = n_eff;
                d.acc_v  = '0;
                d.acc_i  = '0;
                d.acc_p  = '0;
                d.cnt    = '0;
                d.op     = 2'd0;
                d.seq    = SEQ_DLOAD;
            end else begin
                d.acc_v = sum_v;
                d.acc_i = sum_i;
                d.acc_p = sum_p;
                d.cnt   = CW'(cnt_b + 1'b1);
            end
        end else begin
            d.acc_v = acc_vb;
            d.acc_i = acc_ib;
            d.acc_p = acc_pb;
            d.cnt   = cnt_b;
        end

        set_evt          = '0;
        set_evt[ST_CONV] = smp_valid;
        set_evt[ST_DATA] = (q.seq == SEQ_PUB);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.nq  <= CW'(N_RST);
            q.seq <= SEQ_IDLE;
        end else begin
            q <= d;
        end
    end

    pm_serial_div #(.DW(ACC_W), .VW(CW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_dvd),
        .divisor  (q.snap_n),
        .quotient (div_quo),
        .done     (div_done)
    );

    pm_isqrt #(.RW(RAD_W)) u_sqrt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sq_start),
        .radicand (sq_rad),
        .root     (sq_root),
        .done     (sq_done)
    );

    pm_status #(.NB(NSTAT)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (set_evt),
        .clr_wr   (stat_clr_wr),
        .clr_bits (stat_clr_bits),
        .msk_wr   (mask_wr),
        .msk_bits (mask_bits),
        .stat     (status),
        .msk      (mask),
        .irq      (irq)
    );

    assign p_inst = q.p_inst;
    assign v_rms  = q.v_rms;
    assign i_rms  = q.i_rms;
    assign energy = q.energy;
    assign n_low  = (q.nq <= CW'(RMS_MIN_N));

endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int SW = 24,
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic [SW-1:0] v_smp,
    input logic          ncyc_wr,
    input logic [CW-1:0] ncyc_val,
    input logic          stat_clr_wr,
    input logic [1:0]    stat_clr_bits,
    input logic [SW-1:0] p_inst,
    input logic [SW-1:0] v_rms,
    input logic [SW-1:0] i_rms,
    input logic [SW-1:0] energy,
    input logic [1:0]    status,
    input logic [1:0]    mask,
    input logic          irq,
    input logic          n_low
);
    assert_pzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && v_smp == '0) |=> (p_inst == '0));

    assert_conv_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> status[0]);

    assert_results_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(v_rms) && $stable(i_rms) && $stable(energy)) |-> status[1]);

    assert_sticky_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !(stat_clr_wr && stat_clr_bits[0])) |=> status[0]);

    assert_sticky_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !(stat_clr_wr && stat_clr_bits[1])) |=> status[1]);

    assert_mask_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 2'b00) |-> !irq);

    assert_nlow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ncyc_wr && ncyc_val <= CW'(10)) |=> n_low);

endmodule

bind pmeter_cycle_engine pm_checker #(.SW(SW), .CW(CW)) u_pm_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_valid     (smp_valid),
    .v_smp         (v_smp),
    .ncyc_wr       (ncyc_wr),
    .ncyc_val      (ncyc_val),
    .stat_clr_wr   (stat_clr_wr),
    .stat_clr_bits (stat_clr_bits),
    .p_inst        (p_inst),
    .v_rms         (v_rms),
    .i_rms         (i_rms),
    .energy        (energy),
    .status        (status),
    .mask          (mask),
    .irq           (irq),
    .n_low         (n_low)
);

// File: tb/pmeter_cycle_engine_bench.sv
`timescale 1ns/1ps
module pmeter_cycle_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] v_smp = '0, i_smp = '0;
    logic        ncyc_wr = 1'b0;
    logic [23:0] ncyc_val = '0;
    logic        stat_clr_wr = 1'b0;
    logic [1:0]  stat_clr_bits = '0;
    logic        mask_wr = 1'b0;
    logic [1:0]  mask_bits = '0;
    logic [23:0] p_inst, v_rms, i_rms, energy;
    logic [1:0]  status, mask;
    logic        irq, n_low;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    longint m_sv, m_si, m_sp;
    int     m_n, m_cnt;

    always #4 clk = ~clk;

    pmeter_cycle_engine u_pmeter_cycle_engine (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .v_smp(v_smp), .i_smp(i_smp),
        .ncyc_wr(ncyc_wr), .ncyc_val(ncyc_val), .stat_clr_wr(stat_clr_wr),
        .stat_clr_bits(stat_clr_bits), .mask_wr(mask_wr), .mask_bits(mask_bits),
        .p_inst(p_inst), .v_rms(v_rms), .i_rms(i_rms), .energy(energy),
        .status(status), .mask(mask), .irq(irq), .n_low(n_low)
    );

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint isq(longint x);
        longint lo = 0;
        longint hi = 64'd1 << 25;
        while (lo < hi) begin
            longint mid = (lo + hi + 1) / 2;
            if (mid * mid <= x) lo = mid;
            else hi = mid - 1;
        end
        return lo;
    endfunction

    function automatic longint pexp(int v, int i);
        longint pr = longint'(v) * longint'(i);
        if (pr == (64'sd1 <<< 46)) return 64'sd8388607;
        return pr >>> 23;
    endfunction

    function automatic longint rms_exp(longint s, int n);
        longint r = isq(4 * (s / n));
        return (r > 64'sd16777215) ? 64'sd16777215 : r;
    endfunction

    function automatic int sx(logic [23:0] x);
        return int'($signed(x));
    endfunction

    task automatic drive(bit ds, int v, int i, bit dn, int nv, bit dc, logic [1:0] cb, string rt);
        longint pe = 0;
        bit ended = 1'b0;
        longint ev = 0, ei = 0, ee = 0;
        smp_valid = ds; v_smp = v[23:0]; i_smp = i[23:0];
        ncyc_wr = dn; ncyc_val = nv[23:0];
        stat_clr_wr = dc; stat_clr_bits = cb;
        if (dn) begin
            m_n = (nv == 0) ? 1 : nv;
            m_cnt = 0; m_sv = 0; m_si = 0; m_sp = 0;
        end
        if (ds) begin
            pe = pexp(v, i);
            m_sv += longint'(v) * v;
            m_si += longint'(i) * i;
            m_sp += pe;
            m_cnt++;
            if (m_cnt == m_n) begin
                ended = 1'b1;
                ev = rms_exp(m_sv, m_n);
                ei = rms_exp(m_si, m_n);
                ee = m_sp / m_n;
                m_cnt = 0; m_sv = 0; m_si = 0; m_sp = 0;
            end
        end
        @(negedge clk);
        smp_valid = 1'b0; ncyc_wr = 1'b0; stat_clr_wr = 1'b0;
        if (ds) begin
            chk(sx(p_inst) == pe, "R1 power sample", sx(p_inst), pe);
            chk(status[0] == 1'b1, "R2 conversion bit", status[0], 1);
        end
        if (ended) begin
            repeat (320) @(negedge clk);
            chk(v_rms == ev[23:0], {rt, " R3 v_rms"}, v_rms, ev);
            chk(i_rms == ei[23:0], {rt, " R3 i_rms"}, i_rms, ei);
            chk(sx(energy) == ee, {rt, " R4 energy"}, sx(energy), ee);
            chk(status[1] == 1'b1, "R5 data bit", status[1], 1);
        end
    endtask

    task automatic set_mask(logic [1:0] m);
        mask_wr = 1'b1; mask_bits = m;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    function automatic int rnd24();
        return int'($signed(24'($urandom())));
    endfunction

    initial begin
        int seed_init = $urandom(32'd20240611);
        int nlist[4] = '{3, 11, 12, 37};
        m_n = 4000; m_cnt = 0; m_sv = 0; m_si = 0; m_sp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk(status == 2'b00, "R12 status", status, 0);
        chk(mask == 2'b00, "R12 mask", mask, 0);
        chk(v_rms == 0 && i_rms == 0 && energy == 0, "R12 results", v_rms, 0);
        chk(p_inst == 0, "R12 p_inst", p_inst, 0);
        chk(irq == 1'b0, "R12 irq", irq, 0);
        chk(n_low == 1'b0, "R12 N default above limit", n_low, 0);

        // R9 single-conversion cycles
        drive(0, 0, 0, 1, 1, 0, 2'b00, "R9");
        chk(n_low == 1'b1, "R10 n_low N=1", n_low, 1);
        drive(1, 24'sh400000, -24'sh200000, 0, 0, 0, 2'b00, "R9");
        chk(v_rms == 24'h800000, "R9 v_rms is twice |v|", v_rms, 24'h800000);
        chk(energy == p_inst, "R9 energy equals sample", energy, p_inst);

        // R11 saturation at -1
        drive(1, -8388608, -8388608, 0, 0, 0, 2'b00, "R11");
        chk(p_inst == 24'h7FFFFF, "R1 overflow case", p_inst, 24'h7FFFFF);
        chk(v_rms == 24'hFFFFFF && i_rms == 24'hFFFFFF, "R11 rms saturates", v_rms, 24'hFFFFFF);

        // random cycles of several lengths
        foreach (nlist[k]) begin
            drive(0, 0, 0, 1, nlist[k], 0, 2'b00, "R3");
            chk(n_low == (nlist[k] <= 10), "R10 n_low flag", n_low, nlist[k] <= 10);
            for (int s = 0; s < 2 * nlist[k]; s++)
                drive(1, rnd24(), rnd24(), 0, 0, 0, 2'b00, "R3");
        end
        drive(0, 0, 0, 1, 1, 0, 2'b00, "R9");
        for (int s = 0; s < 5; s++)
            drive(1, rnd24(), rnd24(), 0, 0, 0, 2'b00, "R9");

        // R8 restart together with a strobe
        drive(0, 0, 0, 1, 5, 0, 2'b00, "R8");
        drive(1, rnd24(), rnd24(), 0, 0, 0, 2'b00, "R8");
        drive(1, rnd24(), rnd24(), 0, 0, 0, 2'b00, "R8");
        drive(1, 24'sh123456, -24'sh345678, 1, 2, 0, 2'b00, "R8");
        drive(1, -24'sh654321, 24'sh0ABCDE, 0, 0, 0, 2'b00, "R8");
        drive(0, 0, 0, 1, 0, 0, 2'b00, "R8");
        chk(n_low == 1'b1, "R8 zero written acts as one", n_low, 1);
        drive(1, 24'sh7FFFFF, 24'sh7FFFFF, 0, 0, 0, 2'b00, "R8");

        // R6 / R7 status and interrupt
        drive(0, 0, 0, 0, 0, 1, 2'b11, "R6");
        chk(status == 2'b00, "R6 clear both", status, 0);
        set_mask(2'b10);
        drive(0, 0, 0, 1, 4, 0, 2'b00, "R6");
        drive(1, rnd24(), rnd24(), 0, 0, 0, 2'b00, "R7");
        chk(irq == 1'b0, "R7 conversion masked", irq, 0);
        set_mask(2'b01);
        chk(irq == 1'b1, "R7 conversion enabled", irq, 1);
        drive(1, rnd24(), rnd24(), 0, 0, 1, 2'b01, "R6");
        chk(status[0] == 1'b1, "R6 set beats clear", status[0], 1);
        drive(0, 0, 0, 0, 0, 1, 2'b01, "R6");
        chk(status[0] == 1'b0, "R6 clear alone", status[0], 0);
        chk(irq == 1'b0, "R7 irq drops after clear", irq, 0);
        drive(1, rnd24(), rnd24(), 0, 0, 0, 2'b00, "R6");
        drive(1, rnd24(), rnd24(), 0, 0, 0, 2'b00, "R5");
        chk(status[1] == 1'b1 && irq == 1'b1, "R6 data bit holds", status, 3);

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule